// File: doc/BRIEF.md
# UART Event Router

This block sits between a UART's receive and transmit datapaths and the rest of the chip. It turns the UART's condition flags into three request outputs. These are a transmit request, a receive request and one shared status interrupt. The two request lines can feed either a DMA engine or an interrupt controller. The flags it handles are transmitter-holding-empty, a received-word arrival (with an address-word marker), four receive error pulses and the receive FIFO fill level.

Software controls the routing through an 8-bit enable register. That register can be written whole, or single bits can be set or cleared in one write each. Either dedicated request can be moved onto the status interrupt instead of its own line. The status interrupt also collects the line errors, address-word receipt and a FIFO fill-level event. Received-data and address flags are held inside the block until a receive-buffer read strobe. Error flags are held until software writes ones to the status address. A combinational read port returns the enable word or the status word, and reading changes no state.

Top module: `uart_evt_router`

## Requirements
- R1: `tx_req_o` is high exactly when, on the previous clock edge, `thr_empty_i` was high, the enable bit tx_ie (bit 0) was 1 and tx_redir (bit 6) was 0.
- R2: With tx_redir (bit 6) and tx_ie both set, `tx_req_o` stays low and a high `thr_empty_i` raises `stat_irq_o` instead.
- R3: `rx_req_o` is high while the held data-ready flag is set, rx_ie (bit 1) is 1 and rx_redir (bit 7) is 0.
- R4: With rx_redir (bit 7) and rx_ie both set, `rx_req_o` stays low and data-ready raises `stat_irq_o` instead.
- R5: A pulse on `rx_push_i` sets data-ready and loads the address flag from `rx_push_addr_i`. A pulse on `rbr_rd_i` clears both. When both pulses come in the same cycle, the push wins.
- R6: With line_ie (bit 2) set, any held error flag raises `stat_irq_o`. Errors are captured even while line_ie is 0.
- R7: An error pulse on `err_i` (bit 0 parity, 1 framing, 2 break, 3 overrun) is held until a write to address 3 with a one in status bit 2+k. A new error in the same cycle as its clear stays set.
- R8: With addr_ie (bit 3) set, `stat_irq_o` rises when data-ready and the address flag are both set. A word received without the address marker does not raise it.
- R9: With fifo_ie (bit 4) set, the FIFO event raises `stat_irq_o`. When fifo_hi (bit 5) is 0, the event fires at a fill level of 1 or more. When fifo_hi is 1, it fires at a level of `HI_LEVEL` or more.
- R10: A write to address 0 loads the enable word. A write to address 1 ORs data into it. A write to address 2 clears the bits written as one. Addresses 0 to 2 read back the enable word.
- R11: Address 3 reads status as {fifo event, thr_empty, overrun, break, framing, parity, address, data-ready} from bit 7 down to bit 0. Reading has no side effects.
- R12: All three outputs are registered. They change on the first clock edge after the causing input or register write, and they are low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_empty_i | input | 1 | Transmit holding register empty (level) |
| rx_push_i | input | 1 | Received word arrived (pulse) |
| rx_push_addr_i | input | 1 | Arriving word is an address word |
| err_i | input | 4 | Error pulses: parity, framing, break, overrun |
| fifo_level_i | input | LVL_W | Receive FIFO fill level |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_addr_i | input | 2 | Register read address |
| reg_rdata_o | output | 8 | Register read data |
| tx_req_o | output | 1 | Transmit request |
| rx_req_o | output | 1 | Receive request |
| stat_irq_o | output | 1 | Combined status interrupt |

## Verification
The bench samples each output just before and just after the causing edge. A design that reacted combinationally, or one cycle late, is caught by that. It sends a receive push and a buffer read in the same cycle, and an error pulse in the same cycle as its write-one-to-clear. A design that got either priority backwards would drop a word or an error. Redirect tests check both outputs together, so a design that drove both lines, or neither, fails. The threshold test walks the fill level across the high mark with each select value. The set and clear writes are checked against neighbouring bits that must not move.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

    localparam int REG_W = 8;
    localparam int ERR_W = 4;

    typedef enum logic [1:0] {
        A_EN_WR  = 2'd0,
        A_EN_SET = 2'd1,
        A_EN_CLR = 2'd2,
        A_STAT   = 2'd3
    } reg_addr_e;

    // bit 0 is tx_ie, bit 7 is rx_redir
    typedef struct packed {
        logic rx_redir;
        logic tx_redir;
        logic fifo_hi;
        logic fifo_ie;
        logic addr_ie;
        logic line_ie;
        logic rx_ie;
        logic tx_ie;
    } en_t;

    typedef struct packed {
        logic             fifo_evt;
        logic             thre;
        logic [ERR_W-1:0] err;
        logic             addr;
        logic             dr;
    } stat_t;

    typedef struct packed {
        logic line;
        logic addr;
        logic fifo;
        logic tx;
        logic rx;
    } irq_src_t;

    function automatic logic fifo_hit(input logic [7:0] level,
                                      input logic       hi_sel,
                                      input logic [7:0] hi_mark);
        return hi_sel ? (level >= hi_mark) : (level != 8'd0);
    endfunction

endpackage

// File: rtl/uart_evt_enreg.sv
module uart_evt_enreg
    import uart_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  reg_addr_e        addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output en_t              en_n,
    output en_t              en_q
);

    always_comb begin
        en_n = en_q;
        if (wr_i) begin
            case (addr_i)
                A_EN_WR:  en_n = en_t'(wdata_i);
                A_EN_SET: en_n = en_t'(en_q | wdata_i);
                A_EN_CLR: en_n = en_t'(en_q & ~wdata_i);
                default:  en_n = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_n;
    end

endmodule

// File: rtl/uart_evt_flags.sv
module uart_evt_flags
    import uart_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_push_i,
    input  logic             rx_push_addr_i,
    input  logic             rbr_rd_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [ERR_W-1:0] w1c_i,
    output logic             dr_n,
    output logic             addr_n,
    output logic [ERR_W-1:0] err_n,
    output logic             dr_q,
    output logic             addr_q,
    output logic [ERR_W-1:0] err_q
);

    // arrival has priority over the read strobe
    assign dr_n   = rx_push_i | (dr_q & ~rbr_rd_i);
    assign addr_n = rx_push_i ? rx_push_addr_i : (addr_q & ~rbr_rd_i);

    for (genvar k = 0; k < ERR_W; k++) begin : g_err
        // new error beats a same-cycle clear
        assign err_n[k] = err_i[k] | (err_q[k] & ~w1c_i[k]);

        always_ff @(posedge clk) begin
            if (rst) err_q[k] <= 1'b0;
            else     err_q[k] <= err_n[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_q   <= 1'b0;
            addr_q <= 1'b0;
        end else begin
            dr_q   <= dr_n;
            addr_q <= addr_n;
        end
    end

endmodule

// File: rtl/uart_evt_route.sv
module uart_evt_route
    import uart_evt_pkg::*;
#(
    parameter int LVL_W    = 4,
    parameter int HI_LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  en_t              en_i,
    input  logic             thre_i,
    input  logic             dr_i,
    input  logic             addr_i,
    input  logic [ERR_W-1:0] err_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    output logic             tx_req_o,
    output logic             rx_req_o,
    output logic             irq_o
);

    localparam logic [7:0] HI_MARK = 8'(HI_LEVEL);

    logic     tx_evt, rx_evt, fifo_evt;
    irq_src_t src;

    assign tx_evt   = en_i.tx_ie & thre_i;
    assign rx_evt   = en_i.rx_ie & dr_i;
    assign fifo_evt = fifo_hit(8'(fifo_level_i), en_i.fifo_hi, HI_MARK);

    always_comb begin
        src.line = en_i.line_ie & (|err_i);
        src.addr = en_i.addr_ie & dr_i & addr_i;
        src.fifo = en_i.fifo_ie & fifo_evt;
        src.tx   = tx_evt & en_i.tx_redir;
        src.rx   = rx_evt & en_i.rx_redir;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req_o <= 1'b0;
            rx_req_o <= 1'b0;
            irq_o    <= 1'b0;
        end else begin
            tx_req_o <= tx_evt & ~en_i.tx_redir;
            rx_req_o <= rx_evt & ~en_i.rx_redir;
            irq_o    <= |src;
        end
    end

endmodule

// File: rtl/uart_evt_router.sv
module uart_evt_router
    import uart_evt_pkg::*;
#(
    parameter int LVL_W    = 4,
    parameter int HI_LEVEL = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             thr_empty_i,
    input  logic             rx_push_i,
    input  logic             rx_push_addr_i,
    input  logic [3:0]       err_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    input  logic             rbr_rd_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [7:0]       reg_wdata_i,
    input  logic [1:0]       reg_rd_addr_i,
    output logic [7:0]       reg_rdata_o,
    output logic             tx_req_o,
    output logic             rx_req_o,
    output logic             stat_irq_o
);

    localparam logic [7:0] HI_MARK = 8'(HI_LEVEL);

    reg_addr_e        wr_addr;
    en_t              en_n, en_q;
    logic             dr_n, addr_n, dr_q, addr_q;
    logic [ERR_W-1:0] err_n, err_q, w1c;
    stat_t            stat;

    assign wr_addr = reg_addr_e'(reg_addr_i);
    assign w1c     = (reg_wr_i && wr_addr == A_STAT) ? reg_wdata_i[5:2] : '0;

    uart_evt_enreg u_enreg (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr_i),
        .addr_i  (wr_addr),
        .wdata_i (reg_wdata_i),
        .en_n    (en_n),
        .en_q    (en_q)
    );

    uart_evt_flags u_flags (
        .clk            (clk),
        .rst            (rst),
        .rx_push_i      (rx_push_i),
        .rx_push_addr_i (rx_push_addr_i),
        .rbr_rd_i       (rbr_rd_i),
        .err_i          (err_i),
        .w1c_i          (w1c),
        .dr_n           (dr_n),
        .addr_n         (addr_n),
        .err_n          (err_n),
        .dr_q           (dr_q),
        .addr_q         (addr_q),
        .err_q          (err_q)
    );

    uart_evt_route #(
        .LVL_W    (LVL_W),
        .HI_LEVEL (HI_LEVEL)
    ) u_route (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_n),
        .thre_i       (thr_empty_i),
        .dr_i         (dr_n),
        .addr_i       (addr_n),
        .err_i        (err_n),
        .fifo_level_i (fifo_level_i),
        .tx_req_o     (tx_req_o),
        .rx_req_o     (rx_req_o),
        .irq_o        (stat_irq_o)
    );

    always_comb begin
        stat.fifo_evt = fifo_hit(8'(fifo_level_i), en_q.fifo_hi, HI_MARK);
        stat.thre     = thr_empty_i;
        stat.err      = err_q;
        stat.addr     = addr_q;
        stat.dr       = dr_q;
    end

    assign reg_rdata_o = (reg_addr_e'(reg_rd_addr_i) == A_STAT) ? stat : en_q;

endmodule

// File: rtl/uart_evt_router_chk.sv
module uart_evt_router_chk (
    input logic       clk,
    input logic       rst,
    input logic       thr_empty_i,
    input logic       rx_push_i,
    input logic       rbr_rd_i,
    input logic       reg_wr_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] en_q,
    input logic       dr_q,
    input logic [3:0] err_q,
    input logic       tx_req_o,
    input logic       rx_req_o,
    input logic       stat_irq_o
);

    logic [3:0] clr_mask;
    assign clr_mask = (reg_wr_i && reg_addr_i == 2'd3) ? reg_wdata_i[5:2] : 4'h0;

    AST_TX_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_req_o |-> $past(thr_empty_i)); // R1
    AST_TX_REDIR_QUIET: assert property (@(posedge clk) disable iff (rst)
        en_q[6] |-> !tx_req_o); // R2
    AST_RX_NEEDS_DR: assert property (@(posedge clk) disable iff (rst)
        rx_req_o |-> dr_q); // R3
    AST_RX_REDIR_QUIET: assert property (@(posedge clk) disable iff (rst)
        en_q[7] |-> !rx_req_o); // R4
    AST_READ_DROPS_RX: assert property (@(posedge clk) disable iff (rst)
        $past(rbr_rd_i && !rx_push_i) |-> !rx_req_o); // R5
    AST_IRQ_HAS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        stat_irq_o |-> (|(en_q & 8'hDC))); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ((err_q | ~$past(err_q) | $past(clr_mask)) == 4'hF)); // R7
    AST_RESET_LOW: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_req_o && !rx_req_o && !stat_irq_o)); // R12

endmodule

bind uart_evt_router uart_evt_router_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .thr_empty_i (thr_empty_i),
    .rx_push_i   (rx_push_i),
    .rbr_rd_i    (rbr_rd_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .en_q        (en_q),
    .dr_q        (dr_q),
    .err_q       (err_q),
    .tx_req_o    (tx_req_o),
    .rx_req_o    (rx_req_o),
    .stat_irq_o  (stat_irq_o)
);

// File: tb/tb_uart_evt_router.sv
`timescale 1ns/1ps
module tb_uart_evt_router;

    localparam int LVL_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             thr_empty = 1'b0;
    logic             rx_push = 1'b0;
    logic             rx_push_addr = 1'b0;
    logic [3:0]       err = 4'h0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             rbr_rd = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [7:0]       reg_wdata = 8'h00;
    logic [1:0]       rd_addr = 2'd0;
    logic [7:0]       rdata;
    logic             tx_req, rx_req, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_evt_router #(.LVL_W(LVL_W), .HI_LEVEL(4)) dut (
        .clk            (clk),
        .rst            (rst),
        .thr_empty_i    (thr_empty),
        .rx_push_i      (rx_push),
        .rx_push_addr_i (rx_push_addr),
        .err_i          (err),
        .fifo_level_i   (fifo_level),
        .rbr_rd_i       (rbr_rd),
        .reg_wr_i       (reg_wr),
        .reg_addr_i     (reg_addr),
        .reg_wdata_i    (reg_wdata),
        .reg_rd_addr_i  (rd_addr),
        .reg_rdata_o    (rdata),
        .tx_req_o       (tx_req),
        .rx_req_o       (rx_req),
        .stat_irq_o     (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic outs(input string tag, input logic t, input logic r, input logic i);
        chk(tag, {5'b0, tx_req, rx_req, irq}, {5'b0, t, r, i});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic push(input logic a);
        rx_push = 1'b1; rx_push_addr = a;
        step();
        rx_push = 1'b0; rx_push_addr = 1'b0;
    endtask

    task automatic read_buf();
        rbr_rd = 1'b1;
        step();
        rbr_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        outs("R12 reset outputs", 1'b0, 1'b0, 1'b0);
        rd(2'd0, d); chk("R10 reset enables", d, 8'h00);
        rd(2'd3, d); chk("R11 reset status", d, 8'h00);
    endtask

    task automatic t_tx();
        wr(2'd0, 8'h01);
        thr_empty = 1'b1;
        #0.1;
        outs("R12 no change before edge", 1'b0, 1'b0, 1'b0);
        step();
        outs("R1 tx request", 1'b1, 1'b0, 1'b0);
        thr_empty = 1'b0;
        step();
        outs("R1 tx drops", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_tx_redir();
        thr_empty = 1'b1;
        wr(2'd0, 8'h41);
        outs("R2 tx redirected", 1'b0, 1'b0, 1'b1);
        wr(2'd0, 8'h40);
        outs("R2 redirect needs tx_ie", 1'b0, 1'b0, 1'b0);
        thr_empty = 1'b0;
        wr(2'd0, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        wr(2'd0, 8'h02);
        push(1'b0);
        outs("R3 rx request", 1'b0, 1'b1, 1'b0);
        rd(2'd3, d); chk("R5 data-ready set", d, 8'h01);
        step();
        outs("R3 rx held", 1'b0, 1'b1, 1'b0);
        rx_push = 1'b1; rbr_rd = 1'b1;
        step();
        rx_push = 1'b0; rbr_rd = 1'b0;
        outs("R5 push beats read", 1'b0, 1'b1, 1'b0);
        read_buf();
        outs("R5 read clears rx", 1'b0, 1'b0, 1'b0);
        rd(2'd3, d); chk("R5 data-ready cleared", d, 8'h00);
    endtask

    task automatic t_rx_redir();
        wr(2'd0, 8'h82);
        push(1'b0);
        outs("R4 rx redirected", 1'b0, 1'b0, 1'b1);
        read_buf();
        outs("R4 redirect cleared by read", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        wr(2'd0, 8'h08);
        push(1'b1);
        outs("R8 address word irq", 1'b0, 1'b0, 1'b1);
        rd(2'd3, d); chk("R8 address status", d, 8'h03);
        read_buf();
        outs("R8 read clears address irq", 1'b0, 1'b0, 1'b0);
        push(1'b0);
        outs("R8 plain word no irq", 1'b0, 1'b0, 1'b0);
        read_buf();
    endtask

    task automatic t_err();
        logic [7:0] d;
        wr(2'd0, 8'h04);
        err = 4'b0010;
        step();
        err = 4'h0;
        outs("R6 framing irq", 1'b0, 1'b0, 1'b1);
        step();
        outs("R7 error sticky", 1'b0, 1'b0, 1'b1);
        rd(2'd3, d); chk("R7 framing in bit 3", d, 8'h08);
        wr(2'd3, 8'h04);
        outs("R7 other bit clear ignored", 1'b0, 1'b0, 1'b1);
        wr(2'd3, 8'h08);
        outs("R7 W1C clears", 1'b0, 1'b0, 1'b0);
        err = 4'b1000;
        wr(2'd3, 8'h20);
        err = 4'h0;
        rd(2'd3, d); chk("R7 new error beats clear", d, 8'h20);
        outs("R7 irq kept", 1'b0, 1'b0, 1'b1);
        wr(2'd3, 8'h3C);
        wr(2'd0, 8'h00);
        err = 4'b0100;
        step();
        err = 4'h0;
        outs("R6 masked break", 1'b0, 1'b0, 1'b0);
        wr(2'd0, 8'h04);
        outs("R6 captured while masked", 1'b0, 1'b0, 1'b1);
        wr(2'd3, 8'h10);
        outs("R7 break cleared", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_fifo();
        logic [7:0] d;
        wr(2'd0, 8'h10);
        fifo_level = 4'd1;
        step();
        outs("R9 low mark fires", 1'b0, 1'b0, 1'b1);
        wr(2'd0, 8'h30);
        outs("R9 high mark not at 1", 1'b0, 1'b0, 1'b0);
        fifo_level = 4'd4;
        step();
        outs("R9 high mark reached", 1'b0, 1'b0, 1'b1);
        rd(2'd3, d); chk("R11 fifo event bit 7", d, 8'h80);
        fifo_level = 4'd3;
        step();
        outs("R9 below high mark", 1'b0, 1'b0, 1'b0);
        fifo_level = 4'd0;
        wr(2'd0, 8'h10);
        outs("R9 empty fifo", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_setclr();
        logic [7:0] d;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h05); rd(2'd0, d); chk("R10 set bits", d, 8'h05);
        wr(2'd1, 8'h02); rd(2'd1, d); chk("R10 set keeps others", d, 8'h07);
        wr(2'd2, 8'h04); rd(2'd2, d); chk("R10 clear one bit", d, 8'h03);
        wr(2'd0, 8'h00); rd(2'd0, d); chk("R10 direct write", d, 8'h00);
    endtask

    task automatic t_status();
        logic [7:0] d;
        thr_empty = 1'b1;
        push(1'b1);
        rd(2'd3, d); chk("R11 status layout", d, 8'h43);
        step();
        rd(2'd3, d); chk("R11 read no side effect", d, 8'h43);
        outs("R11 outputs unmoved by read", 1'b0, 1'b0, 1'b0);
        read_buf();
        thr_empty = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_tx();
        t_tx_redir();
        t_rx();
        t_rx_redir();
        t_addr();
        t_err();
        t_fifo();
        t_setclr();
        t_status();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule